// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This combinational controller sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Every cycle it compares the register numbers and control bits held in the pipeline registers and drives four kinds of control:

- **Operand bypass selects** for the two execute-stage ALU operands.
- **A load-use stall request.**
- **A front-end enable.** It gates the program counter and the fetch/decode register.
- **Clear strobes.** They turn the fetch/decode and decode/execute registers into bubbles.

The surrounding datapath uses the bypass selects to steer ALU operand muxes. The front-end enable is wired to the enable pins of the PC and fetch/decode registers. The clear strobes go to the synchronous clears of the pipeline registers. When a taken branch or jump resolves in execute, the PC multiplexer loads the target on `redirect`; this unit only decides which registers are squashed.

Top module: `hazard_fwd_unit`

## Requirements
- R1: `front_en` is 1 exactly when `run_en` is 1 and `lu_stall` is 0. When it is 0, the PC and fetch/decode register hold, so the same instruction is fetched again.
- R2: `lu_stall` is 1 when all of the following hold: the execute-stage instruction is a load (`ex_load`=1) with `ex_wr`=1, its `ex_dst` is nonzero, it equals a decode-stage source whose use flag is set, and `redirect` is 0.
- R3: While `lu_stall` is 1, `deex_clear` is 1, which puts a bubble into execute. Once the load has moved on, the stall drops on its own, so the bubble lasts exactly one cycle.
- R4: An operand select is 2'b10 (bypass from the execute/memory register) when `mem_wr`=1, `mem_dst` is nonzero and `mem_dst` equals that operand's execute source.
- R5: An operand select is 2'b01 (bypass from the memory/writeback register) when `wb_wr`=1, `wb_dst` is nonzero, `wb_dst` equals the source, and R4 does not apply. This covers the load result after the stall bubble.
- R6: When both later stages match the same source, the select is 2'b10, so the younger result wins.
- R7: The select is 2'b00 (register file) when no stage matches, when the matching stage has its write flag low, or when the source is register 0.
- R8: Operand B (`fwd_b`, from `ex_src2`) follows R4 to R7 independently of operand A. This supplies a store's data operand from the preceding ALU result.
- R9: On `redirect`=1, `ifde_clear` and `deex_clear` are both 1 and `lu_stall` is 0, even if a load-use hazard is present. `front_en` then follows `run_en`, so the PC can load the target.
- R10: With `redirect`=0 and no load-use hazard, `ifde_clear` and `deex_clear` are 0, so straight-line code never flushes.
- R11: No stall is raised when the execute instruction is not a load, or when a matching decode source has its use flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| run_en | input | 1 | Global pipeline advance enable |
| de_src1 | input | REG_AW | Decode-stage first source register |
| de_src2 | input | REG_AW | Decode-stage second source register |
| de_use1 | input | 1 | Decode instruction reads `de_src1` |
| de_use2 | input | 1 | Decode instruction reads `de_src2` |
| ex_src1 | input | REG_AW | Execute-stage operand A source register |
| ex_src2 | input | REG_AW | Execute-stage operand B (or store data) source register |
| ex_dst | input | REG_AW | Execute-stage destination register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_wr | input | 1 | Execute instruction writes a register |
| mem_dst | input | REG_AW | Execute/memory register destination |
| mem_wr | input | 1 | Execute/memory register write flag |
| wb_dst | input | REG_AW | Memory/writeback register destination |
| wb_wr | input | 1 | Memory/writeback register write flag |
| redirect | input | 1 | Taken branch or jump resolved this cycle |
| fwd_a | output | 2 | Operand A select: 00 regfile, 10 exec/mem, 01 mem/wb |
| fwd_b | output | 2 | Operand B select, same encoding |
| lu_stall | output | 1 | Load-use stall request |
| front_en | output | 1 | Enable for PC and fetch/decode register |
| ifde_clear | output | 1 | Squash the fetch/decode register |
| deex_clear | output | 1 | Squash the decode/execute register (bubble) |

## Verification
The bench builds the unit with `REG_AW` = 5, the default, which gives 32 register numbers. At that width, register 0 and the highest register 31 can both be driven. This lets the zero-register exclusion and full-width comparisons be checked at both ends of the range. A three-cycle load-use sequence is stepped stage by stage, so the bubble length and the later writeback-stage bypass are observed across cycles.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int REG_AW = 5
) (
  input  logic              run_en,
  input  logic [REG_AW-1:0] de_src1,
  input  logic [REG_AW-1:0] de_src2,
  input  logic              de_use1,
  input  logic              de_use2,
  input  logic [REG_AW-1:0] ex_src1,
  input  logic [REG_AW-1:0] ex_src2,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_load,
  input  logic              ex_wr,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  input  logic              redirect,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              lu_stall,
  output logic              front_en,
  output logic              ifde_clear,
  output logic              deex_clear
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam int N_OPS = 2;

  logic [REG_AW-1:0] op_src [N_OPS];
  logic [1:0]        op_sel [N_OPS];
  logic              mem_live, wb_live, load_hit;

  assign op_src[0] = ex_src1;
  assign op_src[1] = ex_src2;
  assign mem_live  = mem_wr && (mem_dst != ZERO_REG);
  assign wb_live   = wb_wr && (wb_dst != ZERO_REG);

  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    assign op_sel[i] = (mem_live && mem_dst == op_src[i]) ? SEL_MEM :
                       (wb_live  && wb_dst  == op_src[i]) ? SEL_WB  : SEL_RF;
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  assign load_hit = ex_load && ex_wr && (ex_dst != ZERO_REG) &&
                    ((de_use1 && de_src1 == ex_dst) || (de_use2 && de_src2 == ex_dst));

  assign lu_stall   = load_hit && !redirect;
  assign front_en   = run_en && !lu_stall;
  assign ifde_clear = redirect;
  assign deex_clear = redirect || lu_stall;
endmodule

module hazard_fwd_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic              run_en,
  input logic [REG_AW-1:0] ex_src1,
  input logic [REG_AW-1:0] ex_src2,
  input logic              redirect,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              lu_stall,
  input logic              front_en,
  input logic              ifde_clear,
  input logic              deex_clear
);
  always_comb begin
    if (!$isunknown({run_en, ex_src1, ex_src2, redirect, fwd_a, fwd_b,
                     lu_stall, front_en, ifde_clear, deex_clear})) begin
      // R1
      stall_holds_front_chk: assert (!(lu_stall && front_en));
      // R3
      stall_bubble_chk: assert (!lu_stall || deex_clear);
      // R9
      flush_beats_stall_chk: assert (!ifde_clear || (!lu_stall && deex_clear));
      // R6
      sel_code_chk: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
      // R7
      zero_src_chk: assert ((fwd_a == 2'b00 || ex_src1 != '0) && (fwd_b == 2'b00 || ex_src2 != '0));
    end
  end
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .run_en(run_en), .ex_src1(ex_src1), .ex_src2(ex_src2), .redirect(redirect),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .lu_stall(lu_stall), .front_en(front_en),
  .ifde_clear(ifde_clear), .deex_clear(deex_clear)
);

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;
  localparam int AW = 5;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic run_en, de_use1, de_use2, ex_load, ex_wr, mem_wr, wb_wr, redirect;
  logic [AW-1:0] de_src1, de_src2, ex_src1, ex_src2, ex_dst, mem_dst, wb_dst;
  logic [1:0] fwd_a, fwd_b;
  logic lu_stall, front_en, ifde_clear, deex_clear;
  int checks = 0, errors = 0;
  bit done = 0;

  hazard_fwd_unit #(.REG_AW(AW)) u_dut (
    .run_en(run_en), .de_src1(de_src1), .de_src2(de_src2), .de_use1(de_use1), .de_use2(de_use2),
    .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_dst(ex_dst), .ex_load(ex_load), .ex_wr(ex_wr),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .wb_dst(wb_dst), .wb_wr(wb_wr), .redirect(redirect),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .lu_stall(lu_stall), .front_en(front_en),
    .ifde_clear(ifde_clear), .deex_clear(deex_clear));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    run_en = 1; redirect = 0;
    de_src1 = 0; de_src2 = 0; de_use1 = 0; de_use2 = 0;
    ex_src1 = 0; ex_src2 = 0; ex_dst = 0; ex_load = 0; ex_wr = 0;
    mem_dst = 0; mem_wr = 0; wb_dst = 0; wb_wr = 0;
  endtask

  task automatic settle(); #1; endtask

  task automatic t_quiet();
    idle(); settle();
    chk("R7 quiet fwd_a", {6'd0, fwd_a}, 8'h0);
    chk("R7 quiet fwd_b", {6'd0, fwd_b}, 8'h0);
    chk("R10 quiet clears", {6'd0, ifde_clear, deex_clear}, 8'h0);
    chk("R2 quiet stall", {7'd0, lu_stall}, 8'h0);
  endtask

  task automatic t_enable_table();
    for (int r = 0; r < 4; r++) begin
      idle();
      run_en = r[0];
      if (r[1]) begin ex_load = 1; ex_wr = 1; ex_dst = 7; de_src1 = 7; de_use1 = 1; end
      settle();
      chk("R1 front_en", {7'd0, front_en}, {7'd0, r[0] & ~r[1]});
      chk("R2 stall row", {7'd0, lu_stall}, {7'd0, r[1]});
    end
  endtask

  task automatic t_load_use_seq();
    idle();
    ex_load = 1; ex_wr = 1; ex_dst = 31; de_src2 = 31; de_use2 = 1; de_src1 = 3; de_use1 = 1;
    settle();
    chk("R2 load-use via src2", {7'd0, lu_stall}, 8'h1);
    chk("R3 bubble", {7'd0, deex_clear}, 8'h1);
    chk("R1 hold front", {7'd0, front_en}, 8'h0);
    chk("R10 no ifde flush on stall", {7'd0, ifde_clear}, 8'h0);
    idle();
    mem_dst = 31; mem_wr = 1; de_src2 = 31; de_use2 = 1;
    settle();
    chk("R3 one-cycle bubble", {6'd0, lu_stall, deex_clear}, 8'h0);
    chk("R3 front resumes", {7'd0, front_en}, 8'h1);
    idle();
    wb_dst = 31; wb_wr = 1; ex_src2 = 31;
    settle();
    chk("R5 load value from wb", {6'd0, fwd_b}, 8'h1);
  endtask

  task automatic t_forwarding();
    idle(); mem_dst = 4; mem_wr = 1; ex_src1 = 4; ex_src2 = 9; settle();
    chk("R4 exmem fwd_a", {6'd0, fwd_a}, 8'h2);
    chk("R8 b independent", {6'd0, fwd_b}, 8'h0);
    idle(); wb_dst = 9; wb_wr = 1; ex_src1 = 9; settle();
    chk("R5 memwb fwd_a", {6'd0, fwd_a}, 8'h1);
    idle(); mem_dst = 6; mem_wr = 1; wb_dst = 6; wb_wr = 1; ex_src1 = 6; ex_src2 = 6; settle();
    chk("R6 priority a", {6'd0, fwd_a}, 8'h2);
    chk("R6 priority b", {6'd0, fwd_b}, 8'h2);
    idle(); mem_dst = 12; mem_wr = 1; ex_src2 = 12; ex_src1 = 1; settle();
    chk("R8 store data fwd_b", {6'd0, fwd_b}, 8'h2);
    chk("R8 fwd_a untouched", {6'd0, fwd_a}, 8'h0);
  endtask

  task automatic t_no_forward();
    idle(); mem_dst = 5; mem_wr = 0; wb_dst = 5; wb_wr = 0; ex_src1 = 5; settle();
    chk("R7 write flag low", {6'd0, fwd_a}, 8'h0);
    idle(); mem_dst = 0; mem_wr = 1; wb_dst = 0; wb_wr = 1; ex_src1 = 0; ex_src2 = 0; settle();
    chk("R7 zero reg a", {6'd0, fwd_a}, 8'h0);
    chk("R7 zero reg b", {6'd0, fwd_b}, 8'h0);
    idle(); mem_dst = 0; mem_wr = 1; wb_dst = 8; wb_wr = 1; ex_src1 = 8; settle();
    chk("R5 wb when mem mismatch", {6'd0, fwd_a}, 8'h1);
  endtask

  task automatic t_no_stall();
    idle(); ex_load = 0; ex_wr = 1; ex_dst = 10; de_src1 = 10; de_use1 = 1; settle();
    chk("R11 alu producer no stall", {7'd0, lu_stall}, 8'h0);
    idle(); ex_load = 1; ex_wr = 1; ex_dst = 10; de_src1 = 10; de_use1 = 0; settle();
    chk("R11 unused source no stall", {7'd0, lu_stall}, 8'h0);
    chk("R11 front runs", {7'd0, front_en}, 8'h1);
    idle(); ex_load = 1; ex_wr = 1; ex_dst = 0; de_src1 = 0; de_use1 = 1; settle();
    chk("R2 zero dst no stall", {7'd0, lu_stall}, 8'h0);
  endtask

  task automatic t_flush();
    idle(); redirect = 1; settle();
    chk("R9 flush clears", {6'd0, ifde_clear, deex_clear}, 8'h3);
    chk("R9 front follows run_en", {7'd0, front_en}, 8'h1);
    idle(); redirect = 1; ex_load = 1; ex_wr = 1; ex_dst = 2; de_src1 = 2; de_use1 = 1; settle();
    chk("R9 flush beats stall", {7'd0, lu_stall}, 8'h0);
    chk("R9 front on flush+hazard", {7'd0, front_en}, 8'h1);
    chk("R9 both clears", {6'd0, ifde_clear, deex_clear}, 8'h3);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_quiet();
    t_enable_table();
    t_load_use_seq();
    t_forwarding();
    t_no_forward();
    t_no_stall();
    t_flush();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule